// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

The block is an event timer that sits on a 32-bit register bus. One 64-bit main counter advances by one every clock while the run bit is set. Several comparator channels watch that counter. Each channel raises a status bit when the counter reaches its comparator value, and the status bit drives an interrupt line.

A channel works in one of two modes. In one-shot mode it fires once. In periodic mode it adds a stored period to its comparator after every match. A channel can also restrict its comparison to the low 32 bits of the counter. Software loads a periodic channel by arming a set-value bit: the next comparator write gives the first match point and the write after that gives the period. A legacy-routing bit takes channels 0 and 1 off the general interrupt lines and sends them to dedicated tick and real-time-clock outputs. Software uses the block by halting the counter, preloading the counter and the channels, and then starting the counter.

Top module: `evt_timer_core`

## Requirements
- R1: After reset the main counter is 0. While the run bit (bit 0 of the general configuration register at 0x010) is 1, the counter increases by exactly one on every clock edge. The run bit reads back at bit 0, the legacy bit at bit 1, and after reset both read 0.
- R2: While the run bit is 0 the counter holds its value. A write to 0x0F0 loads the low 32 bits and a write to 0x0F4 loads the high 32 bits. Both addresses read the current counter halves, and writes to them while the counter runs have no effect.
- R3: The capability register at 0x000 reads the channel count minus one in bits [4:0] and the legacy-routing-supported flag in bit 8. The register at 0x004 reads the counter tick period in femtoseconds.
- R4: The configuration register of channel n is at 0x100+0x20*n. Its bits are: [0] enable, [1] periodic, [2] set-value (always reads 0), [3] 32-bit compare, [5:4] interrupt route. The periodic bit of channel 1 is read-only zero, so a periodic write to that channel leaves it in one-shot mode.
- R5: An enabled one-shot channel sets its status bit on the edge that moves the counter off a value equal to its comparator. It never changes its comparator. A comparator value the counter has already passed fires only after the compared width wraps: the low 32 bits in 32-bit mode, the full 64 bits otherwise.
- R6: On each match, an enabled periodic channel adds its period to the comparator. In 32-bit mode the addition is modulo 2^32 and the high comparator word is left unchanged.
- R7: A configuration write with both the set-value and periodic bits at 1 arms the channel. The next comparator-low write loads the match value and the one after it loads the period, leaving the comparator unchanged. A comparator-low write to an unarmed channel loads only the comparator.
- R8: The comparator of channel n reads back at 0x108+0x20*n (low word) and 0x10C+0x20*n (high word) in the cycle after a write that loaded it.
- R9: The status register at 0x020 holds one bit per channel (bit n for channel n). Writing 1 to a bit clears it. A match in the same cycle as the clear keeps the bit set.
- R10: With the legacy bit 0, interrupt line k is the OR of the status bits of channels whose route field equals k, and the tick and real-time-clock outputs are 0. With the legacy bit 1, channel 0 drives the tick output and channel 1 drives the real-time-clock output, and neither channel reaches the routed lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe for the addressed register |
| bus_addr | input | 12 | Byte address of the register being read or written |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_lines | output | 4 | Routed interrupt lines, one per route value |
| tick_irq | output | 1 | System tick interrupt while legacy routing is on |
| rtc_irq | output | 1 | Real-time-clock interrupt while legacy routing is on |

## Verification
Assertions check the following every cycle:
- The counter steps by one while running and holds while halted.
- A one-shot comparator stays fixed across a match.
- A periodic comparator advances by exactly its period.
- A loaded comparator reads back at once.
- The period write of the set-value sequence leaves the comparator untouched.
- Every match lands in the status register.
- The legacy outputs stay low while routing is normal.

Only the bench's scenarios can show the following:
- The counter value at which each match is first seen.
- The firing of a passed one-shot value after 32-bit wrap, while a 64-bit channel with the same value stays quiet.
- The order of the two writes after arming, and that the period persists across later unarmed writes.
- The switch of channels 0 and 1 between routed lines and legacy outputs.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int DATA_W  = 32;
    localparam int CNT_W   = 64;
    localparam int ADDR_W  = 12;
    localparam int ROUTE_W = 2;
    localparam int NLINES  = 1 << ROUTE_W;

    localparam logic [ADDR_W-1:0] OFS_CAPS   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_GCFG   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h0F4;

    localparam logic [3:0] CH_REGION  = 4'h1;
    localparam logic [2:0] SUB_CFG    = 3'd0;
    localparam logic [2:0] SUB_CMP_LO = 3'd2;
    localparam logic [2:0] SUB_CMP_HI = 3'd3;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               wide32;
        logic               setval;
        logic               periodic;
        logic               enable;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_MATCH,
        SEQ_PERIOD
    } seq_t;

    function automatic logic [DATA_W-1:0] cfg_word(input chan_cfg_t c);
        chan_cfg_t v;
        v        = c;
        v.setval = 1'b0;
        return DATA_W'(v);
    endfunction

endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata[CNT_W-DATA_W-1:0];
        end
    end

    assign cnt = cnt_q;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> cnt_q == $past(cnt_q) + 1'b1);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit PER_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cfg_wr,
    input  logic              cmp_lo_wr,
    input  logic              cmp_hi_wr,
    input  logic [DATA_W-1:0] wdata,
    output chan_cfg_t         cfg,
    output logic [CNT_W-1:0]  cmp,
    output logic              fire
);

    logic               en_q;
    logic               per_q;
    logic               w32_q;
    logic [ROUTE_W-1:0] route_q;
    logic [CNT_W-1:0]   cmp_q;
    logic [CNT_W-1:0]   period_q;
    seq_t               seq_q;

    logic               per_req;
    logic               match;
    logic [CNT_W-1:0]   cmp_next;

    assign per_req = wdata[1] & PER_CAP;

    assign match = w32_q ? (cnt[DATA_W-1:0] == cmp_q[DATA_W-1:0])
                         : (cnt == cmp_q);
    assign fire  = run & en_q & match;

    always_comb begin
        if (w32_q) begin
            cmp_next = {cmp_q[CNT_W-1:DATA_W],
                        cmp_q[DATA_W-1:0] + period_q[DATA_W-1:0]};
        end else begin
            cmp_next = cmp_q + period_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            per_q    <= 1'b0;
            w32_q    <= 1'b0;
            route_q  <= '0;
            cmp_q    <= '0;
            period_q <= '0;
            seq_q    <= SEQ_IDLE;
        end else begin
            if (cfg_wr) begin
                en_q    <= wdata[0];
                per_q   <= per_req;
                w32_q   <= wdata[3];
                route_q <= wdata[5:4];
                if (wdata[2] && per_req) seq_q <= SEQ_MATCH;
            end
            if (cmp_lo_wr) begin
                case (seq_q)
                    SEQ_PERIOD: begin
                        period_q <= CNT_W'(wdata);
                        seq_q    <= SEQ_IDLE;
                    end
                    SEQ_MATCH: begin
                        cmp_q[DATA_W-1:0] <= wdata;
                        seq_q             <= SEQ_PERIOD;
                    end
                    default: cmp_q[DATA_W-1:0] <= wdata;
                endcase
            end else if (cmp_hi_wr) begin
                cmp_q[CNT_W-1:DATA_W] <= wdata[CNT_W-DATA_W-1:0];
            end else if (fire && per_q) begin
                cmp_q <= cmp_next;
            end
        end
    end

    assign cfg = '{route: route_q, wide32: w32_q, setval: 1'b0,
                   periodic: per_q, enable: en_q};
    assign cmp = cmp_q;

    // R6
    periodic_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && per_q && !cmp_lo_wr && !cmp_hi_wr) |=>
        cmp_q[DATA_W-1:0] == $past(cmp_q[DATA_W-1:0]) + $past(period_q[DATA_W-1:0]));

    // R5
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !per_q && !cmp_lo_wr && !cmp_hi_wr) |=> $stable(cmp_q));

    // R8
    cmp_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_lo_wr && seq_q != SEQ_PERIOD) |=> cmp_q[DATA_W-1:0] == $past(wdata));

    // R7
    period_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_lo_wr && seq_q == SEQ_PERIOD) |=>
        ($stable(cmp_q) && period_q[DATA_W-1:0] == $past(wdata)));

endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
    import evt_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [NCH-1:0]         status,
    input  logic [NCH*ROUTE_W-1:0] route_flat,
    input  logic                   legacy,
    output logic [NLINES-1:0]      lines,
    output logic                   tick,
    output logic                   rtc
);

    always_comb begin
        lines = '0;
        for (int l = 0; l < NLINES; l++) begin
            for (int c = 0; c < NCH; c++) begin
                if (!(legacy && c < 2) &&
                    route_flat[c*ROUTE_W +: ROUTE_W] == ROUTE_W'(l)) begin
                    lines[l] = lines[l] | status[c];
                end
            end
        end
    end

    generate
        if (NCH >= 2) begin : g_legacy
            assign tick = legacy & status[0];
            assign rtc  = legacy & status[1];
        end else begin : g_no_legacy
            assign tick = 1'b0;
            assign rtc  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_pkg::*;
#(
    parameter int          NCH          = 3,
    parameter logic [31:0] PERIOD_FS    = 32'd69841279,
    parameter bit          LEG_CAP      = 1'b1,
    parameter logic [31:0] PER_CAP_MASK = 32'hFFFF_FFFD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NLINES-1:0] irq_lines,
    output logic              tick_irq,
    output logic              rtc_irq
);

    localparam bit LEG_OK = LEG_CAP && (NCH >= 2);
    localparam logic [DATA_W-1:0] CAPS_WORD =
        {23'b0, LEG_OK, 3'b0, 5'(NCH - 1)};

    logic             run_q;
    logic             legacy_q;
    logic [NCH-1:0]   status_q;
    logic [CNT_W-1:0] cnt;

    logic             in_ch;
    logic [2:0]       ch_idx;
    logic [2:0]       sub;
    logic             gcfg_wr;
    logic             stat_wr;

    chan_cfg_t            cfg_arr [NCH];
    logic [CNT_W-1:0]     cmp_arr [NCH];
    logic [NCH-1:0]       fire;
    logic [NCH*ROUTE_W-1:0] route_flat;

    assign in_ch   = bus_addr[11:8] == CH_REGION;
    assign ch_idx  = bus_addr[7:5];
    assign sub     = bus_addr[4:2];
    assign gcfg_wr = bus_wr && bus_addr == OFS_GCFG;
    assign stat_wr = bus_wr && bus_addr == OFS_STAT;

    evt_main_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run_q),
        .wr_lo (bus_wr && bus_addr == OFS_CNT_LO),
        .wr_hi (bus_wr && bus_addr == OFS_CNT_HI),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic sel;
            assign sel = bus_wr && in_ch && ch_idx == 3'(c);

            evt_channel #(.PER_CAP(PER_CAP_MASK[c])) u_ch (
                .clk       (clk),
                .rst       (rst),
                .run       (run_q),
                .cnt       (cnt),
                .cfg_wr    (sel && sub == SUB_CFG),
                .cmp_lo_wr (sel && sub == SUB_CMP_LO),
                .cmp_hi_wr (sel && sub == SUB_CMP_HI),
                .wdata     (bus_wdata),
                .cfg       (cfg_arr[c]),
                .cmp       (cmp_arr[c]),
                .fire      (fire[c])
            );

            assign route_flat[c*ROUTE_W +: ROUTE_W] = cfg_arr[c].route;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            legacy_q <= 1'b0;
            status_q <= '0;
        end else begin
            if (gcfg_wr) begin
                run_q    <= bus_wdata[0];
                legacy_q <= LEG_OK & bus_wdata[1];
            end
            for (int c = 0; c < NCH; c++) begin
                status_q[c] <= fire[c] | (status_q[c] & ~(stat_wr & bus_wdata[c]));
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_ch) begin
            for (int c = 0; c < NCH; c++) begin
                if (ch_idx == 3'(c)) begin
                    case (sub)
                        SUB_CFG:    bus_rdata = cfg_word(cfg_arr[c]);
                        SUB_CMP_LO: bus_rdata = cmp_arr[c][DATA_W-1:0];
                        SUB_CMP_HI: bus_rdata = cmp_arr[c][CNT_W-1:DATA_W];
                        default:    bus_rdata = '0;
                    endcase
                end
            end
        end else begin
            case (bus_addr)
                OFS_CAPS:   bus_rdata = CAPS_WORD;
                OFS_PERIOD: bus_rdata = PERIOD_FS;
                OFS_GCFG:   bus_rdata = {30'b0, legacy_q, run_q};
                OFS_STAT:   bus_rdata = DATA_W'(status_q);
                OFS_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
                OFS_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
                default:    bus_rdata = '0;
            endcase
        end
    end

    evt_irq_router #(.NCH(NCH)) u_route (
        .status     (status_q),
        .route_flat (route_flat),
        .legacy     (legacy_q),
        .lines      (irq_lines),
        .tick       (tick_irq),
        .rtc        (rtc_irq)
    );

    // R9
    status_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (fire != '0) |=> (status_q & $past(fire)) == $past(fire));

    // R10
    legacy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !legacy_q |-> (!tick_irq && !rtc_irq));

endmodule

// File: tb/test_evt_timer_core.sv
`timescale 1ns/1ps
module test_evt_timer_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_lines;
    logic        tick_irq;
    logic        rtc_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    evt_timer_core i_evt_timer_core (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines),
        .tick_irq  (tick_irq),
        .rtc_irq   (rtc_irq)
    );

    localparam logic [11:0] A_CAPS = 12'h000, A_PER = 12'h004, A_GCFG = 12'h010,
                            A_STAT = 12'h020, A_CLO = 12'h0F0, A_CHI = 12'h0F4;

    function automatic logic [11:0] a_cfg(input int n);
        return 12'(32'h100 + 32'h20 * n);
    endfunction
    function automatic logic [11:0] a_clo(input int n);
        return 12'(32'h108 + 32'h20 * n);
    endfunction
    function automatic logic [11:0] a_chi(input int n);
        return 12'(32'h10C + 32'h20 * n);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // waits until status bit ch is seen, returns the counter low word at that time
    task automatic wait_fire(input int ch, output logic [31:0] cnt_at, output bit seen);
        logic [31:0] s;
        seen = 1'b0;
        cnt_at = '0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd(A_STAT, s);
            if (s[ch]) begin
                rd(A_CLO, cnt_at);
                seen = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c_at;
        bit          seen;

        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(A_CAPS, v);  check("R3 caps", v, 32'h0000_0102);
        rd(A_PER, v);   check("R3 period", v, 32'd69841279);
        rd(A_GCFG, v);  check("R1 gcfg reset", v, 32'h0);
        rd(A_CLO, v);   check("R1 counter reset", v, 32'h0);
        rd(A_STAT, v);  check("R9 status reset", v, 32'h0);

        // counter load and run
        wr(A_CLO, 32'd100);
        wr(A_CHI, 32'd0);
        rd(A_CLO, v);   check("R2 halted load", v, 32'd100);
        wr(A_GCFG, 32'h1);
        rd(A_GCFG, v);  check("R1 run bit", v, 32'h1);
        wait_cycles(10);
        rd(A_CLO, v);   check("R1 count rate", v, 32'd110);
        wr(A_CHI, 32'h55);
        rd(A_CHI, v);   check("R2 write ignored while running", v, 32'h0);
        wr(A_GCFG, 32'h0);
        rd(A_CLO, v);
        wait_cycles(5);
        begin
            logic [31:0] v2;
            rd(A_CLO, v2);
            check("R2 halted hold", v2, v);
        end

        // channel 1 periodic bit is read-only zero; set-value reads 0
        wr(a_cfg(1), 32'h3);
        rd(a_cfg(1), v);  check("R4 ch1 periodic RO", v, 32'h1);
        wr(a_cfg(1), 32'h0);

        // one-shot on channel 2
        wr(A_CLO, 32'd1000);
        wr(a_cfg(2), 32'h1);
        wr(a_clo(2), 32'd1010);
        wr(a_chi(2), 32'd0);
        rd(a_clo(2), v);  check("R8 readback", v, 32'd1010);
        wr(A_GCFG, 32'h1);
        wait_fire(2, c_at, seen);
        check("R5 one-shot fired", 32'(seen), 32'd1);
        check("R5 one-shot timing", c_at, 32'd1011);
        rd(a_clo(2), v);  check("R5 one-shot cmp unchanged", v, 32'd1010);
        wr(A_STAT, 32'h4);
        rd(A_STAT, v);    check("R9 w1c", v & 32'h4, 32'h0);
        wait_cycles(20);
        rd(A_STAT, v);    check("R5 no refire", v & 32'h4, 32'h0);

        // set-value sequence on channel 0
        wr(A_GCFG, 32'h0);
        wr(a_cfg(2), 32'h0);
        wr(a_cfg(0), 32'h7);
        rd(a_cfg(0), v);  check("R4 setval reads zero", v, 32'h3);
        wr(a_clo(0), 32'd2000);
        wr(a_clo(0), 32'd15);
        rd(a_clo(0), v);  check("R7 second write is period", v, 32'd2000);
        wr(A_CLO, 32'd1990);
        wr(A_STAT, 32'h7);
        wr(A_GCFG, 32'h1);
        wait_fire(0, c_at, seen);
        check("R6 first periodic timing", c_at, 32'd2001);
        rd(a_clo(0), v);  check("R6 advance", v, 32'd2015);
        wr(A_STAT, 32'h1);
        wait_fire(0, c_at, seen);
        check("R6 second periodic timing", c_at, 32'd2016);
        rd(a_clo(0), v);  check("R6 second advance", v, 32'd2030);

        // unarmed write loads only comparator, period kept
        wr(A_GCFG, 32'h0);
        wr(a_clo(0), 32'd3000);
        rd(a_clo(0), v);  check("R7 unarmed loads cmp", v, 32'd3000);
        wr(A_CLO, 32'd2990);
        wr(A_STAT, 32'h7);
        wr(A_GCFG, 32'h1);
        wait_fire(0, c_at, seen);
        check("R7 unarmed timing", c_at, 32'd3001);
        rd(a_clo(0), v);  check("R7 period kept", v, 32'd3015);

        // 32-bit wrap behaviour
        wr(A_GCFG, 32'h0);
        wr(a_cfg(0), 32'hF);
        wr(a_clo(0), 32'hFFFF_FFF8);
        wr(a_clo(0), 32'h10);
        wr(a_chi(0), 32'h0);
        wr(a_cfg(1), 32'h9);
        wr(a_clo(1), 32'd3);
        wr(a_chi(1), 32'd0);
        wr(a_cfg(2), 32'h1);
        wr(a_clo(2), 32'd5);
        wr(a_chi(2), 32'd0);
        wr(A_CLO, 32'hFFFF_FFF0);
        wr(A_CHI, 32'h0);
        wr(A_STAT, 32'h7);
        wr(A_GCFG, 32'h1);
        wait_cycles(35);
        rd(A_CHI, v);     check("R1 carry into high word", v, 32'h1);
        rd(a_clo(0), v);  check("R6 modulo 2^32 add", v, 32'h18);
        rd(a_chi(0), v);  check("R6 high word untouched", v, 32'h0);
        rd(A_STAT, v);    check("R5 wrap fires 32-bit, not 64-bit", v & 32'h7, 32'h3);

        // routing: ch0 route 0, ch1 route 3
        wr(a_cfg(1), 32'h39);
        #0.5;
        check("R10 routed lines", 32'(irq_lines), 32'h9);
        check("R10 legacy outputs off", 32'({tick_irq, rtc_irq}), 32'h0);
        wr(A_GCFG, 32'h3);
        #0.5;
        check("R10 legacy lines", 32'(irq_lines), 32'h0);
        check("R10 legacy outputs", 32'({tick_irq, rtc_irq}), 32'h3);
        rd(A_GCFG, v);    check("R1 legacy bit readback", v, 32'h3);

        // constrained random periodic runs on channels 0 and 2
        wr(A_GCFG, 32'h0);
        wr(a_cfg(1), 32'h0);
        for (int r = 0; r < 6; r++) begin
            int          ch;
            logic [31:0] base, off, per;
            ch   = ($urandom % 2 == 0) ? 0 : 2;
            base = $urandom % 32'h0F00_0000;
            off  = 5 + $urandom % 36;
            per  = 3 + $urandom % 18;
            wr(A_GCFG, 32'h0);
            wr(a_cfg(0), 32'h0);
            wr(a_cfg(2), 32'h0);
            wr(a_cfg(ch), 32'h7);
            wr(a_clo(ch), base + off);
            wr(a_clo(ch), per);
            wr(a_chi(ch), 32'h0);
            wr(A_CLO, base);
            wr(A_CHI, 32'h0);
            wr(A_STAT, 32'h7);
            wr(A_GCFG, 32'h1);
            wait_fire(ch, c_at, seen);
            check("R5 random first match", c_at, base + off + 1);
            rd(a_clo(ch), v);
            check("R7 random match then period", v, base + off + per);
            wr(A_STAT, 32'h7);
            wait_fire(ch, c_at, seen);
            check("R6 random second match", c_at, base + off + per + 1);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule